// File: doc/BRIEF.md
# Chained-Descriptor Receive DMA Channel

This channel takes bytes from a serial frame receiver and stores them in shared memory. It walks a linked ring of packet descriptors. Each descriptor is three 32-bit words at addresses D, D+4 and D+8. The first word is a link to the next descriptor. The second word points to a data buffer. The third word receives the stored length and a status byte. Software gives the first descriptor in the current-pointer register and a stop point in the end-pointer register. The channel fetches descriptors and fills buffers until the current pointer equals the end pointer. It then halts without touching that descriptor. Software frees descriptors by moving the end pointer forward and setting the run bit again.

A frame longer than the programmed buffer length continues into the buffers of the following descriptors. Only the descriptor that holds the frame's last byte carries the end-of-frame bit and the receiver's error flags. A frame that arrives when no descriptor is free is consumed and dropped, and this is recorded in a sticky flag. An end-of-frame interrupt pulse is available, gated by an enable bit.

Top module: `rxdma_chan`

## Requirements
- R1: A descriptor at byte address D is read at D (link) and D+4 (buffer pointer). Its completion is written as one word to D+8 with byte enables 4'b0111. In that word, bits [15:0] hold the stored length and bits [23:16] hold the status byte.
- R2: Fetching starts at the current-pointer register (register 0). When a descriptor completes, register 0 takes that descriptor's link word.
- R3: Data byte k of a buffer is written to buffer pointer + k. The byte enable selects lane addr[1:0] and the byte is repeated in every lane. No buffer receives more bytes than the buffer-length register (register 2).
- R4: A frame longer than the buffer length spills into the following descriptors. Every non-final descriptor gets status 8'h00 and length equal to the buffer length.
- R5: The final descriptor of a frame gets status bit 7 set. Its bits 4:0 copy rx_err sampled with the last byte: bit0 overrun, bit1 short, bit2 abort, bit3 residual bits, bit4 CRC.
- R6: When register 0 equals the end-pointer register (register 1), that descriptor is never read or written. The channel clears the run bit (register 3 bit 0) and sets the halt flag (register 3 bit 4).
- R7: Bytes that arrive while the channel is halted or not running are accepted and discarded, with no memory write. The same applies to the rest of a frame cut short by a halt. At each dropped frame's last byte the drop flag (register 3 bit 6) is set.
- R8: The flags in register 3 are the halt flag (bit 4), end-of-frame (bit 5), drop (bit 6) and frame-count overflow (bit 7). They are cleared by writing ones to them only when bit 1 of the same write is set. A write with bit 1 clear leaves the flags unchanged and loads the run bit from bit 0.
- R9: Setting the run bit restarts a halted channel from register 0.
- R10: Writing 1 to bit 7 of register 4 aborts the channel. The run bit and all flags clear and any frame in progress is abandoned.
- R11: After each final-descriptor write, the end-of-frame flag sets. If that flag was already set, the overflow flag sets as well. eom_irq pulses high for one cycle, but only if register 4 bit 0 is set.
- R12: rx_ready is low while a descriptor is being fetched or written. It is also low while a running channel is preparing to fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| rx_valid | input | 1 | Receive byte present |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Byte ends its frame |
| rx_err | input | 5 | Frame error flags, valid with rx_last |
| rx_ready | output | 1 | Byte is taken on this edge |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write access |
| mem_addr | output | AW | Byte address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after the request |
| eom_irq | output | 1 | End-of-frame interrupt pulse |

## Verification
Suppose the last byte of a frame is taken at edge k. The completion word lands in memory at edge k+1, and register 0 moves at the same edge. eom_irq is high during the cycle after k+1. If the new pointer equals the end pointer, the halt flag and the cleared run bit show after edge k+2. Register writes take effect at the edge that samples them. Reads are combinational, so they are taken one time unit after the following falling edge. The bench waits a fixed ten cycles after each frame before it inspects memory or registers. This stays well past the last of these edges, and dropped frames are checked only after their final byte has been taken.

// File: rtl/rxdma_pkg.sv
`timescale 1ns/1ps
package rxdma_pkg;
    localparam int RA_CUR  = 0;
    localparam int RA_END  = 1;
    localparam int RA_BLEN = 2;
    localparam int RA_STAT = 3;
    localparam int RA_CTRL = 4;

    localparam int SB_RUN = 0;
    localparam int SB_FWE = 1;
    localparam int SB_EOT = 4;
    localparam int SB_EOM = 5;
    localparam int SB_BOF = 6;
    localparam int SB_COF = 7;

    localparam int CB_IE    = 0;
    localparam int CB_ABORT = 7;

    localparam int OFS_BPTR = 4;
    localparam int OFS_TAIL = 8;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CHECK, ST_RDCH, ST_RDBP, ST_LATCH, ST_FILL, ST_WRDESC
    } dstate_t;

    typedef struct packed {
        logic       eom;
        logic [1:0] rsvd;
        logic [4:0] err;
    } dstat_t;

    typedef struct packed {
        logic cof;
        logic bof;
        logic eom;
        logic eot;
    } dflags_t;

    function automatic logic [31:0] desc_tail(input dstat_t s, input logic [15:0] len);
        return {8'h00, s, len};
    endfunction

    function automatic logic [3:0] lane_mask(input logic [1:0] a);
        return 4'b0001 << a;
    endfunction
endpackage

// File: rtl/rxdma_regs.sv
`timescale 1ns/1ps
module rxdma_regs
    import rxdma_pkg::*;
#(
    parameter int AW   = 16,
    parameter int LENW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_wr,
    input  logic [2:0]      reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    input  logic            ev_adv,
    input  logic [AW-1:0]   adv_ptr,
    input  logic            ev_halt,
    input  logic            ev_eom,
    input  logic            ev_bof,
    output logic [AW-1:0]   cur_ptr,
    output logic [AW-1:0]   end_ptr,
    output logic [LENW-1:0] buf_len,
    output logic            run,
    output logic            abort,
    output logic            eom_irq
);
    logic    wr_cur, wr_end, wr_blen, wr_stat, wr_ctrl;
    logic    ie_q, irq_q, run_q;
    dflags_t flags_q, flags_nx;
    logic    unused_w;

    assign unused_w = ^reg_wdata;
    assign wr_cur  = reg_wr && (reg_addr == 3'(RA_CUR));
    assign wr_end  = reg_wr && (reg_addr == 3'(RA_END));
    assign wr_blen = reg_wr && (reg_addr == 3'(RA_BLEN));
    assign wr_stat = reg_wr && (reg_addr == 3'(RA_STAT));
    assign wr_ctrl = reg_wr && (reg_addr == 3'(RA_CTRL));
    assign abort   = wr_ctrl && reg_wdata[CB_ABORT];

    always_comb begin
        flags_nx = flags_q;
        if (wr_stat && reg_wdata[SB_FWE]) begin
            if (reg_wdata[SB_EOT]) flags_nx.eot = 1'b0;
            if (reg_wdata[SB_EOM]) flags_nx.eom = 1'b0;
            if (reg_wdata[SB_BOF]) flags_nx.bof = 1'b0;
            if (reg_wdata[SB_COF]) flags_nx.cof = 1'b0;
        end
        if (ev_halt) flags_nx.eot = 1'b1;
        if (ev_bof)  flags_nx.bof = 1'b1;
        if (ev_eom) begin
            if (flags_nx.eom) flags_nx.cof = 1'b1;
            flags_nx.eom = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_ptr <= '0;
            end_ptr <= '0;
            buf_len <= '0;
            run_q   <= 1'b0;
            ie_q    <= 1'b0;
            irq_q   <= 1'b0;
            flags_q <= '0;
        end else begin
            irq_q <= ev_eom && ie_q;
            if (wr_cur)       cur_ptr <= reg_wdata[AW-1:0];
            else if (ev_adv)  cur_ptr <= adv_ptr;
            if (wr_end)  end_ptr <= reg_wdata[AW-1:0];
            if (wr_blen) buf_len <= reg_wdata[LENW-1:0];
            if (wr_ctrl) ie_q <= reg_wdata[CB_IE];
            if (abort) begin
                run_q   <= 1'b0;
                flags_q <= '0;
            end else begin
                flags_q <= flags_nx;
                if (wr_stat && !reg_wdata[SB_FWE]) run_q <= reg_wdata[SB_RUN];
                else if (ev_halt)                  run_q <= 1'b0;
            end
        end
    end

    assign run     = run_q;
    assign eom_irq = irq_q;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            3'(RA_CUR):  reg_rdata = 32'(cur_ptr);
            3'(RA_END):  reg_rdata = 32'(end_ptr);
            3'(RA_BLEN): reg_rdata = 32'(buf_len);
            3'(RA_STAT): reg_rdata = {24'h0, flags_q.cof, flags_q.bof, flags_q.eom,
                                      flags_q.eot, 3'b000, run_q};
            3'(RA_CTRL): reg_rdata = {31'h0, ie_q};
            default:     reg_rdata = '0;
        endcase
    end

    p_halt_stops_r6: assert property (@(posedge clk) disable iff (rst)
        (ev_halt && !wr_stat && !abort) |=> (!run_q && flags_q.eot));

    p_fwe_gate_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && !reg_wdata[SB_FWE] && !ev_halt && !ev_eom && !ev_bof)
        |=> $stable(flags_q));

    p_irq_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        eom_irq |=> !eom_irq);

    p_irq_gate_r11: assert property (@(posedge clk) disable iff (rst)
        eom_irq |-> $past(ie_q && ev_eom));
endmodule

// File: rtl/rxdma_ctrl.sv
`timescale 1ns/1ps
module rxdma_ctrl
    import rxdma_pkg::*;
#(
    parameter int AW   = 16,
    parameter int LENW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            abort,
    input  logic            run,
    input  logic [AW-1:0]   cur_ptr,
    input  logic [AW-1:0]   end_ptr,
    input  logic [LENW-1:0] buf_len,
    input  logic            rx_valid,
    input  logic [7:0]      rx_data,
    input  logic            rx_last,
    input  logic [4:0]      rx_err,
    output logic            rx_ready,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [3:0]      mem_be,
    output logic [31:0]     mem_wdata,
    input  logic [31:0]     mem_rdata,
    output logic            ev_adv,
    output logic [AW-1:0]   adv_ptr,
    output logic            ev_halt,
    output logic            ev_eom,
    output logic            ev_bof
);
    dstate_t         state;
    logic [AW-1:0]   chain_q, bptr_q;
    logic [LENW-1:0] cnt_q, cnt_inc;
    dstat_t          stat_q;
    logic            in_frame_q, drop_q, at_end, unused_r;

    assign unused_r = ^mem_rdata;
    assign at_end   = (cur_ptr == end_ptr);
    assign cnt_inc  = cnt_q + 1'b1;

    always_comb begin
        rx_ready  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_ptr;
        mem_be    = 4'b0000;
        mem_wdata = '0;
        ev_adv    = 1'b0;
        adv_ptr   = chain_q;
        ev_eom    = 1'b0;
        case (state)
            ST_IDLE:  rx_ready = !(run && !drop_q);
            ST_RDCH:  mem_req = 1'b1;
            ST_RDBP: begin
                mem_req  = 1'b1;
                mem_addr = cur_ptr + AW'(OFS_BPTR);
            end
            ST_FILL: begin
                rx_ready  = 1'b1;
                mem_req   = rx_valid;
                mem_we    = 1'b1;
                mem_addr  = bptr_q + AW'(cnt_q);
                mem_be    = lane_mask(mem_addr[1:0]);
                mem_wdata = {4{rx_data}};
            end
            ST_WRDESC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_ptr + AW'(OFS_TAIL);
                mem_be    = 4'b0111;
                mem_wdata = desc_tail(stat_q, 16'(cnt_q));
                ev_adv    = 1'b1;
                ev_eom    = stat_q.eom;
            end
            default: ;
        endcase
    end

    assign ev_halt = (state == ST_CHECK) && run && at_end;
    assign ev_bof  = (state == ST_IDLE) && rx_ready && rx_valid && rx_last;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            state      <= ST_IDLE;
            chain_q    <= '0;
            bptr_q     <= '0;
            cnt_q      <= '0;
            stat_q     <= '0;
            in_frame_q <= 1'b0;
            drop_q     <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (rx_ready && rx_valid) drop_q <= !rx_last;
                    else if (run && !drop_q)  state  <= ST_CHECK;
                end
                ST_CHECK: begin
                    if (!run || at_end) begin
                        drop_q     <= in_frame_q;
                        in_frame_q <= 1'b0;
                        state      <= ST_IDLE;
                    end else begin
                        state <= ST_RDCH;
                    end
                end
                ST_RDCH: state <= ST_RDBP;
                ST_RDBP: begin
                    chain_q <= mem_rdata[AW-1:0];
                    state   <= ST_LATCH;
                end
                ST_LATCH: begin
                    bptr_q <= mem_rdata[AW-1:0];
                    cnt_q  <= '0;
                    state  <= ST_FILL;
                end
                ST_FILL: begin
                    if (rx_valid) begin
                        cnt_q <= cnt_inc;
                        if (rx_last) begin
                            stat_q     <= '{eom: 1'b1, rsvd: 2'b00, err: rx_err};
                            in_frame_q <= 1'b0;
                            state      <= ST_WRDESC;
                        end else if (cnt_inc == buf_len) begin
                            stat_q     <= '0;
                            in_frame_q <= 1'b1;
                            state      <= ST_WRDESC;
                        end
                    end
                end
                ST_WRDESC: state <= ST_CHECK;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    p_no_end_fetch_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> !at_end);

    p_fill_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FILL && buf_len != '0) |-> (cnt_q < buf_len));

    p_tail_single_r1: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_be == 4'b0111) |=> (state == ST_CHECK || state == ST_IDLE));

    p_busy_stall_r12: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !(state == ST_FILL)) |-> !rx_ready);
endmodule

// File: rtl/rxdma_chan.sv
`timescale 1ns/1ps
module rxdma_chan
    import rxdma_pkg::*;
#(
    parameter int AW   = 16,
    parameter int LENW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_last,
    input  logic [4:0]    rx_err,
    output logic          rx_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [3:0]    mem_be,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          eom_irq
);
    logic            ev_adv, ev_halt, ev_eom, ev_bof, run, abort;
    logic [AW-1:0]   adv_ptr, cur_ptr, end_ptr;
    logic [LENW-1:0] buf_len;

    rxdma_regs #(.AW(AW), .LENW(LENW)) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_adv(ev_adv), .adv_ptr(adv_ptr), .ev_halt(ev_halt),
        .ev_eom(ev_eom), .ev_bof(ev_bof),
        .cur_ptr(cur_ptr), .end_ptr(end_ptr), .buf_len(buf_len),
        .run(run), .abort(abort), .eom_irq(eom_irq)
    );

    rxdma_ctrl #(.AW(AW), .LENW(LENW)) u_ctrl (
        .clk(clk), .rst(rst), .abort(abort), .run(run),
        .cur_ptr(cur_ptr), .end_ptr(end_ptr), .buf_len(buf_len),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .rx_err(rx_err), .rx_ready(rx_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .ev_adv(ev_adv), .adv_ptr(adv_ptr), .ev_halt(ev_halt),
        .ev_eom(ev_eom), .ev_bof(ev_bof)
    );
endmodule

// File: tb/rxdma_chan_bench.sv
`timescale 1ns/1ps
module rxdma_chan_bench;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_data = '0;
    logic          rx_last = 1'b0;
    logic [4:0]    rx_err = '0;
    logic          rx_ready;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [3:0]    mem_be;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;
    logic          eom_irq;

    logic [31:0] mem [0:1023];
    logic [7:0]  sent [0:63];
    int total = 0, bad = 0, irq_cnt = 0;

    always #2 clk = ~clk;

    rxdma_chan #(.AW(AW)) u_rxdma_chan (.*);

    always @(posedge clk) begin
        if (mem_req && mem_we)
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        mem_rdata <= mem[mem_addr[11:2]];
    end

    always @(negedge clk) if (!rst && eom_irq) irq_cnt++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 3'(a);
        #1 d = reg_rdata;
    endtask

    task automatic send_frame(input int n, input logic [4:0] err);
        for (int k = 0; k < n; k++) begin
            sent[k] = 8'($urandom);
            @(negedge clk);
            rx_valid = 1'b1; rx_data = sent[k];
            rx_last = (k == n - 1); rx_err = (k == n - 1) ? err : 5'h0;
            while (!rx_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    function automatic logic [31:0] dtail(input int idx);
        return mem[(32'h100 + 12 * idx + 8) >> 2];
    endfunction

    function automatic int byte_miss(input int first, input int n);
        int miss = 0;
        for (int k = 0; k < n; k++) begin
            int a = 32'h200 + 32'h40 * ((first + k / 8) % 4) + k % 8;
            if (mem[a >> 2][8 * (a % 4) +: 8] !== sent[k]) miss++;
        end
        return miss;
    endfunction

    initial begin
        #(4 * 200000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [4:0]  errb;
        void'($urandom(32'd1234));
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        for (int i = 0; i < 4; i++) begin
            mem[(32'h100 + 12 * i) >> 2]     = 32'h100 + 12 * ((i + 1) % 4);
            mem[(32'h100 + 12 * i + 4) >> 2] = 32'h200 + 32'h40 * i;
            mem[(32'h100 + 12 * i + 8) >> 2] = 32'h00AA_0000;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rd(3, v); chk("R8 reset status", v, 32'h0);
        rd(0, v); chk("R2 reset pointer", v, 32'h0);

        wr(2, 8); wr(0, 32'h100); wr(1, 32'h124); wr(4, 1);
        wr(3, 1);
        chk("R12 stall before fetch", 32'(rx_ready), 0);
        send_frame(5, 5'h0);
        chk("R1 length field", dtail(0) & 32'hFFFF, 5);
        chk("R5 final status", (dtail(0) >> 16) & 32'hFF, 32'h80);
        chk("R3 buffer bytes", byte_miss(0, 5), 0);
        rd(0, v); chk("R2 follows link", v, 32'h10C);
        chk("R11 irq count", irq_cnt, 1);
        rd(3, v); chk("R11 eom flag", v, 32'h21);
        wr(3, 32'hF1);
        rd(3, v); chk("R8 no clear without enable bit", v, 32'h21);
        wr(3, 32'h22);
        rd(3, v); chk("R8 clear by ones", v, 32'h01);

        errb = 5'(($urandom % 31) + 1);
        send_frame(11, errb);
        chk("R4 fragment word", dtail(1), 32'h0000_0008);
        chk("R5 last fragment", dtail(2), {8'h0, 3'b100, errb, 16'd3});
        chk("R4 spanned bytes", byte_miss(1, 11), 0);
        rd(3, v); chk("R6 halt at end", v, 32'h30);

        send_frame(4, 5'h0);
        chk("R7 end descriptor untouched", dtail(3), 32'h00AA_0000);
        rd(3, v); chk("R7 drop flag", v, 32'h70);

        wr(3, 32'hF2); wr(1, 32'h100); wr(3, 1);
        send_frame(3, 5'h0);
        chk("R9 restart result", dtail(3), 32'h0080_0003);
        chk("R9 restart bytes", byte_miss(3, 3), 0);
        rd(0, v); chk("R2 ring wrap", v, 32'h100);
        chk("R11 irq total", irq_cnt, 3);

        wr(3, 32'hF2); wr(4, 0); wr(1, 32'h118); wr(3, 1);
        send_frame(2, 5'h0);
        send_frame(2, 5'h0);
        chk("R11 irq masked", irq_cnt, 3);
        rd(3, v); chk("R11 overflow flag", v, 32'hB0);

        wr(3, 32'hF2); wr(1, 32'h124); wr(3, 1);
        send_frame(12, 5'h0);
        chk("R7 partial fragment", dtail(2), 32'h0000_0008);
        rd(3, v); chk("R7 partial drop", v, 32'h50);

        wr(4, 32'h80);
        rd(3, v); chk("R10 abort clears", v, 32'h0);
        chk("R10 idle accepts", 32'(rx_ready), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule